// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side access port and a PCI configuration bus. It accepts two kinds of access. The first kind is a direct-mapped configuration window. In that window each target device is selected by a single address bit. The second kind goes through the usual pair of 32-bit index and data registers in I/O space. Each accepted access becomes a configuration cycle. The cycle carries a 15-bit address made of a 4-bit device number and an 11-bit function and register offset, together with byte enables and lane-aligned write data. Read data comes back from the target and is right-aligned before it is returned.

In the system the window occupies a 4 MiB region. Its CPU base address is 0x8080_0000, and the decoder above this block removes that base and passes in the 22-bit offset. The I/O path is selected with `is_io`. Little-endian byte order applies everywhere: byte lane n carries data bits [8n+7:8n].

Top module: `cfg_addr_xlate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no configuration cycle (`cfg_req`) and no read response (`rsp_valid`) are produced. Reset clears the index register to 0.
- R2: On a window access, the device number (`cfg_addr[14:11]`) is the position, counted from 0, of the lowest set bit among offset bits 11 to 21. The other set bits in that range are ignored.
- R3: On a window access with offset bits 11 to 21 all clear, the device number is 11.
- R4: On a window access, `cfg_addr[10:0]` equals offset bits [10:0] unchanged, so `cfg_addr = off[10:0] | (device << 11)`. The cycle appears in the cycle after the request.
- R5: Access size is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. The byte enables are `1<<off[1:0]` for a byte, `3<<(2*off[1])` for a halfword and `4'hF` for a word. Write data is moved to the same lanes, little-endian.
- R6: Every read request receives exactly one response, two cycles after the request. The addressed lanes are shifted down to bit 0 and the unused upper bits are zero.
- R7: When the target does not assert `cfg_hit`, a read returns all ones, limited to the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R8: The index register is at I/O offset 0xCF8. It can be written byte by byte using the R5 enables and can be read back. Accesses to it never create a configuration cycle.
- R9: The data register is at I/O offset 0xCFC. When index bit 31 is set, an access to it creates a cycle with address `{index[14:2], off[1:0]}` and byte enables as in R5.
- R10: When index bit 31 is clear, data-register reads return all ones and data-register writes create no cycle, so the target keeps its contents.
- R11: Accesses to any other I/O offset create no cycle, and reads of them return all ones.
- R12: Writes never produce a read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| is_io | input | 1 | 1 = I/O space access, 0 = direct window access |
| off | input | 22 | Window offset, or I/O offset in the low 12 bits |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data, right-aligned |
| cfg_req | output | 1 | Configuration cycle strobe |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_addr | output | 15 | Device number and function/register offset |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Target read data, valid while `cfg_req` is high |
| cfg_hit | input | 1 | Target present, valid while `cfg_req` is high |

## Verification
The bench sets several select bits at once, so a decoder that favoured the highest bit, or one that encoded the select bits in binary, would send the cycle to the wrong device. It tests an offset with no select bit set and one with only bit 21 set, which catches a decoder that falls back to device 0 or stops one bit short. Narrow reads and writes on odd lanes expose enables or data shifts pointing the wrong way. Clearing index bit 31 with a byte write and then re-enabling it shows whether a write that should have been dropped reached the target anyway.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int OFF_W  = 22,
  parameter int SEL_LO = 11,
  parameter int NSEL   = 11,
  parameter int DW     = 32,
  parameter int IO_IDX = 12'hCF8,
  parameter int IO_DAT = 12'hCFC,
  localparam int DEV_W = $clog2(NSEL + 1),
  localparam int CA_W  = SEL_LO + DEV_W,
  localparam int NB    = DW / 8,
  localparam int LB    = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             is_io,
  input  logic [OFF_W-1:0] off,
  input  logic             we,
  input  logic [1:0]       size,
  input  logic [DW-1:0]    wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [CA_W-1:0]  cfg_addr,
  output logic [NB-1:0]    cfg_be,
  output logic [DW-1:0]    cfg_wdata,
  input  logic [DW-1:0]    cfg_rdata,
  input  logic             cfg_hit
);

  logic [DW-1:0]    idx_q;
  logic [DEV_W-1:0] dev;
  logic [LB-1:0]    lane, sh;
  logic [NB-1:0]    be_c;
  logic [DW-1:0]    wsh;
  logic             hit_idx, hit_dat, go;
  logic [CA_W-1:0]  addr_c;

  logic             rd_q, src_cfg_q;
  logic [DW-1:0]    loc_q;
  logic [LB-1:0]    sh_q;
  logic [1:0]       sz_q;
  logic [DW-1:0]    raw, down;

  assign lane    = off[LB-1:0];
  assign hit_idx = is_io && (off[OFF_W-1:2] == (OFF_W-2)'(IO_IDX >> 2));
  assign hit_dat = is_io && (off[OFF_W-1:2] == (OFF_W-2)'(IO_DAT >> 2));
  assign go      = req && (!is_io || (hit_dat && idx_q[DW-1]));

  always_comb begin
    dev = DEV_W'(NSEL);
    for (int i = NSEL - 1; i >= 0; i--)
      if (off[SEL_LO+i]) dev = DEV_W'(i);
  end

  always_comb begin
    case (size)
      2'd0: begin
        sh   = lane;
        be_c = NB'(1) << lane;
      end
      2'd1: begin
        sh   = {lane[LB-1:1], 1'b0};
        be_c = NB'(3) << sh;
      end
      default: begin
        sh   = '0;
        be_c = '1;
      end
    endcase
  end

  assign wsh    = wdata << {sh, 3'b000};
  assign addr_c = is_io ? {idx_q[CA_W-1:2], lane} : {dev, off[SEL_LO-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (req && hit_idx && we) begin
      for (int b = 0; b < NB; b++)
        if (be_c[b]) idx_q[8*b +: 8] <= wsh[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      rd_q      <= 1'b0;
      src_cfg_q <= 1'b0;
      loc_q     <= '0;
      sh_q      <= '0;
      sz_q      <= '0;
    end else begin
      cfg_req   <= go;
      cfg_we    <= go && we;
      cfg_addr  <= go ? addr_c : '0;
      cfg_be    <= go ? be_c : '0;
      cfg_wdata <= go ? wsh : '0;
      rd_q      <= req && !we;
      src_cfg_q <= go && !we;
      loc_q     <= hit_idx ? idx_q : '1;
      sh_q      <= sh;
      sz_q      <= size;
    end
  end

  assign raw  = src_cfg_q ? (cfg_hit ? cfg_rdata : '1) : loc_q;
  assign down = raw >> {sh_q, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_q;
      case (sz_q)
        2'd0:    rsp_data <= {{(DW-8){1'b0}}, down[7:0]};
        2'd1:    rsp_data <= {{(DW-16){1'b0}}, down[15:0]};
        default: rsp_data <= down;
      endcase
    end
  end

endmodule

module cfg_addr_xlate_chk #(
  parameter int OFF_W  = 22,
  parameter int SEL_LO = 11,
  parameter int NSEL   = 11,
  parameter int CA_W   = 15,
  parameter int NB     = 4,
  parameter int IO_DAT = 12'hCFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             is_io,
  input logic [OFF_W-1:0] off,
  input logic             we,
  input logic [1:0]       size,
  input logic             cfg_req,
  input logic [CA_W-1:0]  cfg_addr,
  input logic [NB-1:0]    cfg_be,
  input logic             rsp_valid
);

  // R4
  low_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && $past(req && !is_io) |-> cfg_addr[SEL_LO-1:0] == $past(off[SEL_LO-1:0]));

  // R2
  lowest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && $past(req && !is_io && off[SEL_LO]) |-> cfg_addr[CA_W-1:SEL_LO] == '0);

  // R3
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && $past(req && !is_io && off[SEL_LO+NSEL-1:SEL_LO] == '0)
      |-> cfg_addr[CA_W-1:SEL_LO] == (CA_W-SEL_LO)'(NSEL));

  // R5
  byte_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && $past(size == 2'd0) |-> $countones(cfg_be) == 1);

  // R6
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req && !we, 2));

  // R11
  io_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && is_io && off[OFF_W-1:2] != (OFF_W-2)'(IO_DAT >> 2)) |-> !cfg_req);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !cfg_req && !rsp_valid);

endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk #(
  .OFF_W(OFF_W), .SEL_LO(SEL_LO), .NSEL(NSEL), .CA_W(CA_W), .NB(NB), .IO_DAT(IO_DAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .is_io(is_io), .off(off), .we(we),
  .size(size), .cfg_req(cfg_req), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
  .rsp_valid(rsp_valid)
);

// File: tb/sim_cfg_addr_xlate.sv
module sim_cfg_addr_xlate;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, is_io = 0, we = 0;
  logic [21:0] off = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid, cfg_req, cfg_we, cfg_hit;
  logic [31:0] rsp_data, cfg_wdata, cfg_rdata;
  logic [14:0] cfg_addr;
  logic [3:0]  cfg_be;

  always #2 clk = ~clk;

  cfg_addr_xlate u0 (.*);

  logic [31:0] mem [16][32];
  initial
    for (int d = 0; d < 16; d++)
      for (int r = 0; r < 32; r++)
        mem[d][r] = 32'hC0DE0000 | (d << 8) | r;

  assign cfg_hit   = cfg_req && (cfg_addr[14:11] == 4'd2 || cfg_addr[14:11] == 4'd5);
  assign cfg_rdata = mem[cfg_addr[14:11]][cfg_addr[6:2]];

  always @(posedge clk)
    if (cfg_req && cfg_we && cfg_hit)
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) mem[cfg_addr[14:11]][cfg_addr[6:2]][8*b +: 8] <= cfg_wdata[8*b +: 8];

  typedef struct packed {
    logic [14:0] a;
    logic        w;
    logic [3:0]  be;
    logic [31:0] d;
  } cyc_t;

  cyc_t        q_cyc[$];
  string       t_cyc[$];
  logic [31:0] q_rd[$];
  string       t_rd[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cfg_req) begin
      cyc_t got, e;
      got = '{cfg_addr, cfg_we, cfg_be, cfg_wdata};
      if (q_cyc.size() == 0) chk(0, "R10/R11 unexpected cycle", 64'(got), 0);
      else begin
        string t;
        e = q_cyc.pop_front();
        t = t_cyc.pop_front();
        chk(got == e, t, 64'(got), 64'(e));
      end
    end
    if (rsp_valid) begin
      if (q_rd.size() == 0) chk(0, "R12 unexpected response", 64'(rsp_data), 0);
      else begin
        string t;
        logic [31:0] e;
        e = q_rd.pop_front();
        t = t_rd.pop_front();
        chk(rsp_data == e, t, 64'(rsp_data), 64'(e));
      end
    end
  end

  task automatic acc(bit io, logic [21:0] o, bit w, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    req = 1; is_io = io; off = o; we = w; size = s; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic ecyc(logic [14:0] a, bit w, logic [3:0] be, logic [31:0] d, string t);
    q_cyc.push_back('{a, w, be, d});
    t_cyc.push_back(t);
  endtask

  task automatic erd(logic [31:0] d, string t);
    q_rd.push_back(d);
    t_rd.push_back(t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cfg_req && !rsp_valid, "R1 quiet in reset", {cfg_req, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cfg_req && !rsp_valid, "R1 quiet after reset", {cfg_req, rsp_valid}, 0);
    erd(32'h0, "R1 index cleared");
    acc(1, 22'hCF8, 0, 2, 0);

    ecyc(15'h1010, 0, 4'hF, 0, "R2 R4 word read dev2");
    erd(32'hC0DE0204, "R6 word read dev2");
    acc(0, (22'h1 << 13) | 22'h10, 0, 2, 0);

    ecyc(15'h1020, 0, 4'hF, 0, "R2 lowest of several bits");
    erd(32'hC0DE0208, "R2 data dev2");
    acc(0, (22'h1 << 16) | (22'h1 << 13) | (22'h1 << 20) | 22'h20, 0, 2, 0);

    ecyc(15'h5FFC, 0, 4'hF, 0, "R3 no select bit");
    erd(32'hFFFFFFFF, "R7 absent word");
    acc(0, 22'h7FC, 0, 2, 0);

    ecyc(15'h5004, 0, 4'hF, 0, "R2 bit 21 only");
    erd(32'hFFFFFFFF, "R7 absent dev10");
    acc(0, (22'h1 << 21) | 22'h4, 0, 3, 0);

    ecyc(15'h2809, 1, 4'b0010, 32'h00005A00, "R5 byte write lane1");
    acc(0, (22'h1 << 16) | 22'h9, 1, 0, 32'h5A);
    ecyc(15'h2808, 0, 4'hF, 0, "R4 dev5 readback");
    erd(32'hC0DE5A02, "R5 byte merged");
    acc(0, (22'h1 << 16) | 22'h8, 0, 2, 0);

    ecyc(15'h280A, 0, 4'b1100, 0, "R5 half be upper");
    erd(32'h0000C0DE, "R6 half aligned down");
    acc(0, (22'h1 << 16) | 22'hA, 0, 1, 0);

    ecyc(15'h0803, 0, 4'b1000, 0, "R5 byte be lane3");
    erd(32'h000000FF, "R7 absent byte");
    acc(0, (22'h1 << 12) | 22'h3, 0, 0, 0);

    acc(1, 22'hCF8, 1, 2, 32'h80001010);
    erd(32'h80001010, "R8 index readback");
    acc(1, 22'hCF8, 0, 2, 0);

    ecyc(15'h1010, 0, 4'hF, 0, "R9 data read via index");
    erd(32'hC0DE0204, "R9 data value");
    acc(1, 22'hCFC, 0, 2, 0);

    ecyc(15'h1012, 1, 4'b0100, 32'h00770000, "R9 data byte write");
    acc(1, 22'hCFE, 1, 0, 32'h77);
    ecyc(15'h1010, 0, 4'hF, 0, "R9 readback cycle");
    erd(32'hC0770204, "R9 readback value");
    acc(1, 22'hCFC, 0, 2, 0);

    acc(1, 22'hCFB, 1, 0, 32'h00);
    erd(32'h00001010, "R8 byte write index");
    acc(1, 22'hCF8, 0, 2, 0);
    erd(32'hFFFFFFFF, "R10 disabled read");
    acc(1, 22'hCFC, 0, 2, 0);
    acc(1, 22'hCFC, 1, 2, 32'h12345678);

    acc(1, 22'hCFB, 1, 0, 32'h80);
    ecyc(15'h1010, 0, 4'hF, 0, "R10 reenabled cycle");
    erd(32'hC0770204, "R10 write was dropped");
    acc(1, 22'hCFC, 0, 2, 0);

    erd(32'hFFFFFFFF, "R11 other io read");
    acc(1, 22'hCF0, 0, 2, 0);
    acc(1, 22'hCF4, 1, 2, 32'hDEADBEEF);

    repeat (6) @(negedge clk);
    chk(q_cyc.size() == 0, "R9 missing cycle", q_cyc.size(), 0);
    chk(q_rd.size() == 0, "R6 missing response", q_rd.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule